// File: doc/BRIEF.md
# Frame-Synchronised Hardware Lock Bank

This block holds ten hardware lock slots that let software and a display pipeline agree on when configuration may change. Each slot owns a small group of 32-bit registers on a simple memory-mapped bus. These registers are an enable bit, a lock request with a read-only granted flag, a self-clearing reset bit, a frame-start source select, and two 32-bit membership words that together name up to 64 pipeline modules.

Software takes a slot in three steps. It enables the slot, writes 1 to the request bit, and polls the granted flag. The grant does not come at once. It waits for a frame boundary, which is the next rising edge of the frame-start input the slot selects. In free-running mode the grant comes one clock after the request. While a slot is enabled and nobody has requested it, every rising edge of its selected frame-start input becomes a one-cycle update pulse on each module output named in its membership words. Pipeline modules use these pulses to latch their shadowed settings. When several slots name the same module, their pulses are ORed together.

Top module: `mtxb_bank`

## Requirements
- R1: Slot n (0..9) owns the word addresses 0x20+0x20·n plus an offset. The offsets and fields are: +0x00 enable (bit 0), +0x04 lock (bit 0 request, read/write; bit 1 granted, read-only), +0x08 reset (bit 0), +0x0C low membership word, +0x10 frame-start source (bits 2:0), +0x14 high membership word. Every written field reads back its value.
- R2: A read of any other address returns 0, and so does any address whose low two bits are not zero. Writes to such addresses change no register.
- R3: With source code 0 (free-running), the granted flag is still 0 in the cycle after the edge that stores the request write. It reads 1 after the following edge.
- R4: Source codes 1..6 select frame-start input bit (code−1). A pending request is granted at the first clock edge that samples that input high after it was sampled low. Edges on the other inputs grant nothing.
- R5: Writing 0 to the lock register clears both the request and the granted flag at the edge that stores the write.
- R6: For an enabled slot with its request bit clear, a rising edge of the selected input that is sampled at clock edge E drives upd_o high in the cycle after E. It drives bit k for every set bit k of the low word and bit 32+k for every set bit k of the high word.
- R7: A slot whose request bit is set, a disabled slot, or a slot with source code 0 or 7 produces no update pulses.
- R8: When several slots fire in the same cycle, upd_o is the OR of their membership sets.
- R9: Writing 1 to reset bit 0 makes the reset register read 1 for one cycle. At the next edge, the slot's request, granted flag and both membership words are cleared and the reset bit reads 0 again. Enable and source stay as they were.
- R10: After global reset, every register reads 0 and upd_o is 0.
- R11: Each update pulse lasts exactly one cycle, even when the frame-start input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| fs_evt_i | input | 6 | Frame-start event inputs, level signals |
| upd_o | output | 64 | Per-module update pulses |

## Verification
The bench aims at the cycle when a grant arrives, in both free-running and frame-synchronised mode. A design that granted on the request edge itself, or granted on the wrong frame input, would show the flag one cycle early or on a foreign event. It also checks that a requested slot and a disabled slot give no pulses, while another slot sharing a module still pulses. A design that ORed wrongly, or forgot to suppress, would show the wrong pulse set. The self-clearing reset is checked to keep enable and source, and a frame input held high is checked to give only one pulse. Broken decoding would show as aliasing onto unmapped or misaligned addresses.

// File: rtl/mtxb_pkg.sv
package mtxb_pkg;
    localparam int DATA_W   = 32;
    localparam int NUM_SRC  = 6;
    localparam int SRC_W    = 3;
    localparam int NUM_MODS = 2 * DATA_W;

    typedef enum logic [2:0] {
        RG_EN   = 3'd0,
        RG_LOCK = 3'd1,
        RG_RST  = 3'd2,
        RG_LO   = 3'd3,
        RG_SRC  = 3'd4,
        RG_HI   = 3'd5
    } reg_e;

    typedef struct packed {
        logic              en;
        logic              req;
        logic              grant;
        logic              rst_pend;
        logic [SRC_W-1:0]  src;
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
    } slot_st_t;
endpackage

// File: rtl/mtxb_decode.sv
module mtxb_decode
    import mtxb_pkg::*;
#(
    parameter int NUM_SLOTS = 10,
    parameter int ADDR_W    = 12,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [SLOT_W-1:0] slot_o,
    output reg_e              reg_o
);
    localparam int ROW_W = ADDR_W - 5;
    localparam logic [ROW_W-1:0] FIRST_ROW = ROW_W'(1);
    localparam logic [ROW_W-1:0] LAST_ROW  = ROW_W'(NUM_SLOTS);

    logic [ROW_W-1:0] row;
    logic [2:0]       field;

    always_comb begin
        row    = addr_i[ADDR_W-1:5];
        field  = addr_i[4:2];
        hit_o  = (addr_i[1:0] == 2'b00) && (row >= FIRST_ROW) &&
                 (row <= LAST_ROW) && (field <= 3'd5);
        slot_o = SLOT_W'(row - FIRST_ROW);
        reg_o  = reg_e'(field);
    end
endmodule

// File: rtl/mtxb_edge.sv
module mtxb_edge #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] lvl_d, lvl_q;

    always_comb begin
        lvl_d  = lvl_i;
        rise_o = lvl_i & ~lvl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end
endmodule

// File: rtl/mtxb_slot.sv
module mtxb_slot
    import mtxb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_i,
    input  logic                we_i,
    input  reg_e                reg_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [NUM_SRC-1:0]  rise_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [NUM_MODS-1:0] pulse_o,
    output logic                req_o,
    output logic                grant_o
);
    slot_st_t st_d, st_q;
    logic     sel_rise;
    logic     grant_fire;

    always_comb begin
        sel_rise = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (int'(st_q.src) == s + 1) sel_rise = rise_i[s];
        end
        grant_fire = (st_q.src == '0) || sel_rise;

        st_d = st_q;
        if (st_q.rst_pend) begin
            st_d.req      = 1'b0;
            st_d.grant    = 1'b0;
            st_d.lo       = '0;
            st_d.hi       = '0;
            st_d.rst_pend = 1'b0;
        end else if (st_q.req && grant_fire) begin
            st_d.grant = 1'b1;
        end

        if (we_i && sel_i) begin
            unique case (reg_i)
                RG_EN:   st_d.en = wdata_i[0];
                RG_LOCK: begin
                    st_d.req = wdata_i[0];
                    if (!wdata_i[0]) st_d.grant = 1'b0;
                end
                RG_RST:  st_d.rst_pend = wdata_i[0];
                RG_LO:   st_d.lo  = wdata_i;
                RG_SRC:  st_d.src = wdata_i[SRC_W-1:0];
                RG_HI:   st_d.hi  = wdata_i;
                default: ;
            endcase
        end

        unique case (reg_i)
            RG_EN:   rdata_o = {{(DATA_W-1){1'b0}}, st_q.en};
            RG_LOCK: rdata_o = {{(DATA_W-2){1'b0}}, st_q.grant, st_q.req};
            RG_RST:  rdata_o = {{(DATA_W-1){1'b0}}, st_q.rst_pend};
            RG_LO:   rdata_o = st_q.lo;
            RG_SRC:  rdata_o = {{(DATA_W-SRC_W){1'b0}}, st_q.src};
            RG_HI:   rdata_o = st_q.hi;
            default: rdata_o = '0;
        endcase

        pulse_o = (st_q.en && !st_q.req && sel_rise) ? {st_q.hi, st_q.lo} : '0;
        req_o   = st_q.req;
        grant_o = st_q.grant;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mtxb_bank.sv
module mtxb_bank
    import mtxb_pkg::*;
#(
    parameter int NUM_SLOTS = 10,
    parameter int ADDR_W    = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [DATA_W-1:0]   bus_wdata_i,
    output logic [DATA_W-1:0]   bus_rdata_o,
    input  logic [NUM_SRC-1:0]  fs_evt_i,
    output logic [NUM_MODS-1:0] upd_o
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);

    logic                hit;
    logic [SLOT_W-1:0]   slot;
    reg_e                rsel;
    logic [NUM_SRC-1:0]  rise;
    logic [DATA_W-1:0]   slot_rd    [NUM_SLOTS];
    logic [NUM_MODS-1:0] slot_pulse [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] slot_req;
    logic [NUM_SLOTS-1:0] slot_grant;
    logic [NUM_MODS-1:0] upd_d, upd_q;

    mtxb_decode #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_dec (
        .addr_i (bus_addr_i),
        .hit_o  (hit),
        .slot_o (slot),
        .reg_o  (rsel)
    );

    mtxb_edge #(.W(NUM_SRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (fs_evt_i),
        .rise_o (rise)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic sel;
        assign sel = hit && (slot == SLOT_W'(g));
        mtxb_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_i   (sel),
            .we_i    (bus_we_i),
            .reg_i   (rsel),
            .wdata_i (bus_wdata_i),
            .rise_i  (rise),
            .rdata_o (slot_rd[g]),
            .pulse_o (slot_pulse[g]),
            .req_o   (slot_req[g]),
            .grant_o (slot_grant[g])
        );
    end

    always_comb begin
        upd_d = '0;
        for (int i = 0; i < NUM_SLOTS; i++) upd_d = upd_d | slot_pulse[i];
        bus_rdata_o = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (hit && slot == SLOT_W'(i)) bus_rdata_o = slot_rd[i];
        end
        upd_o = upd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) upd_q <= '0;
        else        upd_q <= upd_d;
    end
endmodule

// File: rtl/mtxb_bank_chk.sv
module mtxb_bank_chk #(
    parameter int NUM_SLOTS = 10,
    parameter int ADDR_W    = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr_i,
    input logic [31:0]          bus_rdata_o,
    input logic [63:0]          upd_o,
    input logic [NUM_SLOTS-1:0] slot_req,
    input logic [NUM_SLOTS-1:0] slot_grant
);
    logic off_map;
    always_comb begin
        off_map = (bus_addr_i[1:0] != 2'b00) || (bus_addr_i[4:2] > 3'd5) ||
                  (int'(bus_addr_i) < 32) ||
                  (int'(bus_addr_i) >= 32 * (NUM_SLOTS + 1));
    end

    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        off_map |-> bus_rdata_o == '0);

    p_pulse_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_o != '0) |=> (upd_o == '0));

    p_grant_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_grant & ~slot_req) == '0);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_chk
        p_grant_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(slot_grant[g]) |-> $past(slot_req[g]));
        p_release_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(slot_req[g]) |-> !slot_grant[g]);
    end
endmodule

bind mtxb_bank mtxb_bank_chk #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .upd_o       (upd_o),
    .slot_req    (slot_req),
    .slot_grant  (slot_grant)
);

// File: tb/tb_mtxb_bank.sv
module tb_mtxb_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [5:0]  fs = '0;
    logic [63:0] upd;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    mtxb_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .fs_evt_i(fs), .upd_o(upd)
    );

    function automatic logic [11:0] ra(int s, int off);
        return 12'(32 + 32 * s + off);
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
        addr = a; #1;
        chk(req, 64'(rdata), 64'(exp));
    endtask

    task automatic fs_rise(int b);
        @(negedge clk); fs[b] = 1'b1;
        @(negedge clk);
    endtask

    task automatic fs_fall(int b);
        @(negedge clk); fs[b] = 1'b0;
    endtask

    task automatic t_reset;
        rd_chk("R10 enable", ra(0, 0), 0);
        rd_chk("R10 lock", ra(9, 4), 0);
        rd_chk("R10 mask", ra(5, 12), 0);
        chk("R10 upd", upd, 0);
    endtask

    task automatic t_map;
        wr(ra(3, 12), 32'hA5A5_0F0F);
        wr(ra(9, 20), 32'h1234_5678);
        wr(ra(3, 16), 32'd5);
        wr(ra(7, 0), 32'd1);
        rd_chk("R1 low word", ra(3, 12), 32'hA5A5_0F0F);
        rd_chk("R1 high word", ra(9, 20), 32'h1234_5678);
        rd_chk("R1 source", ra(3, 16), 32'd5);
        rd_chk("R1 enable", ra(7, 0), 32'd1);
        wr(ra(7, 0), 32'd0);
        rd_chk("R1 enable off", ra(7, 0), 32'd0);
        wr(ra(3, 16), 32'd0);
    endtask

    task automatic t_unmapped;
        wr(12'h000, 32'hFFFF_FFFF);
        wr(ra(1, 24), 32'hFFFF_FFFF);
        wr(ra(10, 12), 32'hFFFF_FFFF);
        rd_chk("R2 below base", 12'h000, 0);
        rd_chk("R2 hole", ra(1, 24), 0);
        rd_chk("R2 past end", ra(10, 12), 0);
        rd_chk("R2 misaligned", ra(3, 13), 0);
        rd_chk("R2 no alias", ra(0, 12), 0);
    endtask

    task automatic t_single;
        wr(ra(0, 0), 1);
        wr(ra(0, 4), 1);
        rd_chk("R3 not yet", ra(0, 4), 32'd1);
        @(negedge clk);
        rd_chk("R3 granted", ra(0, 4), 32'd3);
        wr(ra(0, 4), 0);
        rd_chk("R5 released", ra(0, 4), 32'd0);
        wr(ra(0, 0), 0);
    endtask

    task automatic t_sync;
        wr(ra(2, 16), 32'd3);
        wr(ra(2, 4), 1);
        repeat (3) @(negedge clk);
        rd_chk("R4 waits for frame", ra(2, 4), 32'd1);
        fs_rise(0);
        rd_chk("R4 foreign input", ra(2, 4), 32'd1);
        fs_fall(0);
        fs_rise(2);
        rd_chk("R4 granted on edge", ra(2, 4), 32'd3);
        fs_fall(2);
        wr(ra(2, 4), 0);
        rd_chk("R5 sync release", ra(2, 4), 32'd0);
    endtask

    task automatic t_pulse;
        logic [63:0] e;
        e = (64'd1 << 5) | (64'd1 << 35);
        wr(ra(4, 16), 32'd2);
        wr(ra(4, 12), 32'h20);
        wr(ra(4, 20), 32'h8);
        wr(ra(4, 0), 1);
        fs_rise(1);
        chk("R6 pulse set", upd, e);
        @(negedge clk);
        chk("R11 one cycle", upd, 0);
        @(negedge clk);
        chk("R11 held level", upd, 0);
        fs_fall(1);
    endtask

    task automatic t_or_suppress;
        wr(ra(5, 16), 32'd2);
        wr(ra(5, 12), 32'hA0);
        wr(ra(5, 0), 1);
        fs_rise(1);
        chk("R8 union", upd, (64'd1 << 5) | (64'd1 << 7) | (64'd1 << 35));
        fs_fall(1);
        wr(ra(4, 4), 1);
        fs_rise(1);
        chk("R7 requested slot quiet", upd, (64'd1 << 5) | (64'd1 << 7));
        fs_fall(1);
        wr(ra(4, 4), 0);
        wr(ra(4, 0), 0);
        wr(ra(5, 0), 0);
        fs_rise(1);
        chk("R7 disabled quiet", upd, 0);
        fs_fall(1);
        wr(ra(5, 0), 1);
        wr(ra(5, 16), 32'd7);
        fs_rise(1);
        chk("R7 code 7 quiet", upd, 0);
        fs_fall(1);
        wr(ra(5, 0), 0);
    endtask

    task automatic t_slot_reset;
        wr(ra(4, 0), 1);
        wr(ra(4, 4), 1);
        wr(ra(4, 8), 1);
        rd_chk("R9 reset pending", ra(4, 8), 32'd1);
        @(negedge clk);
        rd_chk("R9 self clear", ra(4, 8), 0);
        rd_chk("R9 lock cleared", ra(4, 4), 0);
        rd_chk("R9 low cleared", ra(4, 12), 0);
        rd_chk("R9 high cleared", ra(4, 20), 0);
        rd_chk("R9 enable kept", ra(4, 0), 32'd1);
        rd_chk("R9 source kept", ra(4, 16), 32'd2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_unmapped();
        t_single();
        t_sync();
        t_pulse();
        t_or_suppress();
        t_slot_reset();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule